// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 32K words by 8 bits. The host hands over one word-sized read or write at a time on a valid/ready request channel. The controller then drives the RAM's active-low chip-select, write-strobe and output-enable pins with phase lengths that satisfy the RAM's access, pulse-width, setup and bus-release times. The RAM's bidirectional data pins are modelled as separate out, in and drive-enable signals. A finished access is reported with a one-cycle response pulse, which carries the read data for reads.

Each phase length is a whole number of clock cycles. It is computed when the design is built: the timing figure in nanoseconds is divided by the clock period, the result is rounded up, and it is never less than one. Every access runs through the same fixed sequence: a setup cycle with all strobes inactive, a strobe phase, a recovery phase with all strobes inactive, and a response cycle. The address and write data are captured when a request is accepted. Back-pressure works as follows: `req_ready` is high only while the controller is idle. A request transfers on a cycle where `req_valid` and `req_ready` are both high. The response channel has no ready, so the host must take `rsp_valid` on the cycle it appears.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_dq_oe` is 0, and `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all 1.
- R2: `req_ready` is 1 only while no access is in progress. A `req_valid` held high during an access starts no second access, and the chip strobes are all inactive whenever `req_ready` is 1.
- R3: The address, data and direction of an access are those present at acceptance. Changes on `req_addr`, `req_wdata` and `req_we` after acceptance do not affect the access.
- R4: A write (`req_we`=1) holds `mem_ce_n` and `mem_we_n` low together for exactly max(ceil(tWP), ceil(tDW), ceil(tAW)) cycles, 3 with the defaults. `mem_oe_n` stays 1 throughout.
- R5: `mem_dq_oe` is 1 only while `mem_we_n` is 0 and `mem_oe_n` is 1, and it is 1 for every cycle of the write pulse, with `mem_dq_out` equal to the accepted write data.
- R6: A read (`req_we`=0) holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for exactly max(ceil(tAA), ceil(tOE)) cycles, 4 with the defaults. `rsp_rdata` is the value on `mem_dq_in` in the last cycle of that phase.
- R7: After the read strobe ends, `mem_dq_oe` stays 0 for at least ceil(tHZ) cycles, 2 with the defaults.
- R8: `mem_addr` does not change between two consecutive cycles in which any strobe is low.
- R9: `rsp_valid` is high for exactly one cycle, 1 + strobe + recovery clock edges after the accepting edge. This is 7 for a read and 5 for a write with the defaults.
- R10: The write recovery lasts max(1, ceil(tWC) - 1 - write strobe) cycles, so setup, strobe and recovery together cover at least the write cycle time.
- R11: All phase counts round the nanosecond figure up to whole cycles and are at least 1. The setup phase, from tAS = 0 ns, is therefore 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request may transfer |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle access-complete pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid after a read |
| mem_addr | output | 15 | RAM address pins |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_in | input | 8 | Data seen on the RAM data pins |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |

## Verification
The assertions assume that the RAM itself never forces the controller's pins, and that the host leaves `req_valid` free to stay high across an access. The per-pulse counters in the checker assume that one strobe phase is always separated from the next by at least one inactive cycle. The stimulus keeps to this: every request goes through the controller's own handshake, and some requests keep `req_valid` high with scrambled fields until the response appears. The bench's RAM model shows data only once the access time in cycles has passed, and it presents the inverted data before then.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RECOVER,
    ST_DONE
  } asram_state_e;

  // Round a nanosecond figure up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int SETUP_CYC = 1,
  parameter int WR_STB    = 3,
  parameter int WR_REC    = 1,
  parameter int RD_STB    = 4,
  parameter int RD_REC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             op_we,
  input  logic             last,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic             rsp_valid
);
  asram_state_e state_q, state_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d  = ST_SETUP;
        load     = 1'b1;
        load_val = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (last) begin
        state_d  = ST_STROBE;
        load     = 1'b1;
        load_val = op_we ? CNT_W'(WR_STB - 1) : CNT_W'(RD_STB - 1);
      end
      ST_STROBE: if (last) begin
        state_d  = ST_RECOVER;
        load     = 1'b1;
        load_val = op_we ? CNT_W'(WR_REC - 1) : CNT_W'(RD_REC - 1);
        capture  = !op_we;
      end
      ST_RECOVER: if (last) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // Pin strobes are flops decoded from the next state: no decode glitches.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ce_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      ce_n      <= !(state_d == ST_STROBE);
      we_n      <= !((state_d == ST_STROBE) && op_we);
      oe_n      <= !((state_d == ST_STROBE) && !op_we);
      dq_oe     <= (state_d == ST_STROBE) && op_we;
      rsp_valid <= (state_d == ST_DONE);
    end
  end
endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              op_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_we      <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      op_we      <= req_we;
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rsp_rdata <= '0;
    else if (capture) rsp_rdata <= mem_dq_in;
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int T_AS_NS = 0,
  parameter int T_WP_NS = 25,
  parameter int T_DW_NS = 20,
  parameter int T_AW_NS = 30,
  parameter int T_WC_NS = 35,
  parameter int T_AA_NS = 35,
  parameter int T_OE_NS = 25,
  parameter int T_HZ_NS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);
  localparam int SETUP_CYC = int'(ns_to_cyc(T_AS_NS, CLK_NS));
  localparam int WR_STB    = int'(max2(max2(ns_to_cyc(T_WP_NS, CLK_NS),
                                            ns_to_cyc(T_DW_NS, CLK_NS)),
                                       ns_to_cyc(T_AW_NS, CLK_NS)));
  localparam int WC_CYC    = int'(ns_to_cyc(T_WC_NS, CLK_NS));
  localparam int WR_REC    = (WC_CYC > SETUP_CYC + WR_STB) ? (WC_CYC - SETUP_CYC - WR_STB) : 1;
  localparam int RD_STB    = int'(max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
  localparam int RD_REC    = int'(ns_to_cyc(T_HZ_NS, CLK_NS));
  localparam int MAX_PH    = int'(max2(max2(SETUP_CYC, WR_STB), max2(max2(WR_REC, RD_STB), RD_REC)));
  localparam int CNT_W     = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;

  logic             accept, capture, load, last, op_we;
  logic [CNT_W-1:0] load_val;

  asram_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .last     (last)
  );

  asram_seq #(
    .CNT_W     (CNT_W),
    .SETUP_CYC (SETUP_CYC),
    .WR_STB    (WR_STB),
    .WR_REC    (WR_REC),
    .RD_STB    (RD_STB),
    .RD_REC    (RD_REC)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .op_we     (op_we),
    .last      (last),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .load      (load),
    .load_val  (load_val),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe),
    .rsp_valid (rsp_valid)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .op_we      (op_we),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_rdata  (rsp_rdata)
  );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W  = 15,
  parameter int WR_STB  = 3,
  parameter int RD_STB  = 4,
  parameter int REL_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n
);
  logic [7:0] we_run, oe_run, rel_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run  <= '0;
      oe_run  <= '0;
      rel_cnt <= 8'hff;
    end else begin
      we_run  <= !mem_we_n ? ((we_run == 8'hff) ? we_run : we_run + 8'd1) : 8'd0;
      oe_run  <= !mem_oe_n ? ((oe_run == 8'hff) ? oe_run : oe_run + 8'd1) : 8'd0;
      rel_cnt <= !mem_oe_n ? 8'd0 : ((rel_cnt == 8'hff) ? rel_cnt : rel_cnt + 8'd1);
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R4
  wr_strobe_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  // R4
  wr_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (we_run < 8'(WR_STB)));

  // R5
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n && !mem_ce_n));

  // R6
  rd_strobe_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n && (oe_run < 8'(RD_STB))));

  // R7
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (rel_cnt >= 8'(REL_CYC)));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .WR_STB  (WR_STB),
  .RD_STB  (RD_STB),
  .REL_CYC (RD_REC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_dq_oe (mem_dq_oe),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;
  localparam int CLK_NS = 10;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_WR_STB = imax(imax(cyc(25), cyc(20)), cyc(30));
  localparam int E_WR_REC = (cyc(35) > 1 + E_WR_STB) ? cyc(35) - 1 - E_WR_STB : 1;
  localparam int E_RD_STB = imax(cyc(35), cyc(25));
  localparam int E_RD_REC = cyc(15);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;
  logic [7:0]  rsp_rdata, mem_dq_out;
  logic [14:0] mem_addr;
  logic [7:0]  ram_dq = 8'h00;

  always #5 clk = ~clk;

  asram_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_in  (ram_dq),
    .mem_dq_oe  (mem_dq_oe),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] ram_m [int unsigned];
  logic [7:0] ref_m [int unsigned];

  function automatic logic [7:0] ram_get(input logic [14:0] a);
    return ram_m.exists(int'(a)) ? ram_m[int'(a)] : 8'h00;
  endfunction
  function automatic logic [7:0] ref_get(input logic [14:0] a);
    return ref_m.exists(int'(a)) ? ref_m[int'(a)] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // RAM model and pin monitors, all at the falling edge.
  int rd_cnt = 0, rel_cnt = 99, we_run = 0, oe_run = 0, we_w = 0, oe_w = 0;
  int addr_err = 0, drv_err = 0, rel_err = 0, nodrv_err = 0, ovl_err = 0;
  bit strobe_prev = 0;
  logic [14:0] addr_prev = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit strobe_now;
      if (!mem_ce_n && !mem_we_n) begin
        if (!mem_dq_oe) nodrv_err++;
        ram_m[int'(mem_addr)] = mem_dq_out;
      end
      if (!mem_we_n && !mem_oe_n) ovl_err++;
      if (mem_dq_oe && (!mem_oe_n || mem_we_n || mem_ce_n)) drv_err++;
      if (!mem_oe_n) rel_cnt = 0;
      else if (rel_cnt < 99) rel_cnt++;
      if (mem_dq_oe && rel_cnt <= E_RD_REC) rel_err++;
      strobe_now = !mem_ce_n || !mem_we_n || !mem_oe_n;
      if (strobe_prev && strobe_now && mem_addr != addr_prev) addr_err++;
      strobe_prev = strobe_now;
      addr_prev = mem_addr;
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin we_w = we_run; we_run = 0; end
      if (!mem_oe_n) oe_run++;
      else if (oe_run != 0) begin oe_w = oe_run; oe_run = 0; end
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt++;
      else rd_cnt = 0;
      ram_dq = (rd_cnt >= E_RD_STB) ? ram_get(mem_addr) : ~ram_get(mem_addr);
    end
  end

  task automatic do_op(input bit we, input logic [14:0] a, input logic [7:0] d, input bit scramble);
    int lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    // R2: busy once accepted
    chk(req_ready == 1'b0, "R2", "ready during access", int'(req_ready), 0);
    if (scramble) begin
      // R3: valid held high with changed fields until the response
      req_we = ~we; req_addr = ~a; req_wdata = ~d;
    end else req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 50) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (we) begin
      ref_m[int'(a)] = d;
      // R9 R10 R11: write latency
      chk(lat == 1 + E_WR_STB + E_WR_REC, "R10", "write latency", lat, 1 + E_WR_STB + E_WR_REC);
      // R4: write pulse length
      chk(we_w == E_WR_STB, "R4", "write pulse cycles", we_w, E_WR_STB);
    end else begin
      // R9 R11: read latency
      chk(lat == 1 + E_RD_STB + E_RD_REC, "R9", "read latency", lat, 1 + E_RD_STB + E_RD_REC);
      // R6: read strobe length and data
      chk(oe_w == E_RD_STB, "R6", "read strobe cycles", oe_w, E_RD_STB);
      chk(rsp_rdata == ref_get(a), "R6", "read data", int'(rsp_rdata), int'(ref_get(a)));
    end
    @(negedge clk);
    // R9: single-cycle response
    chk(rsp_valid == 1'b0, "R9", "response width", int'(rsp_valid), 0);
  endtask

  initial begin
    logic [14:0] pool [16];
    void'($urandom(32'd4321));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
    chk(mem_dq_oe == 1'b0, "R1", "mem_dq_oe", int'(mem_dq_oe), 0);
    chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b111, "R1", "strobes", int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);

    // Directed corners: address extremes, unwritten word, held-valid scramble.
    do_op(1'b1, 15'h0000, 8'h3c, 1'b0);
    do_op(1'b1, 15'h7fff, 8'hc3, 1'b0);
    do_op(1'b0, 15'h7fff, 8'h00, 1'b0);
    do_op(1'b0, 15'h0000, 8'h00, 1'b0);
    do_op(1'b0, 15'h0100, 8'h00, 1'b0);
    do_op(1'b1, 15'h1234, 8'h99, 1'b1);
    do_op(1'b0, 15'h1234, 8'h00, 1'b1);
    // R3: the scrambled addresses must not have been written
    do_op(1'b0, ~15'h1234, 8'h00, 1'b0);
    do_op(1'b0, 15'h0000, 8'h00, 1'b0);
    do_op(1'b1, 15'h0000, 8'h5a, 1'b0);

    for (int i = 0; i < 16; i++) pool[i] = 15'($urandom);
    pool[0] = 15'h0000; pool[1] = 15'h7fff;
    for (int i = 0; i < 80; i++) begin
      do_op(1'($urandom), pool[$urandom % 16], 8'($urandom), 1'($urandom));
    end
    for (int i = 0; i < 16; i++) do_op(1'b0, pool[i], 8'h00, 1'b0);

    chk(addr_err == 0, "R8", "address moved under strobe", addr_err, 0);
    chk(drv_err == 0, "R5", "drive outside write pulse", drv_err, 0);
    chk(nodrv_err == 0, "R5", "write pulse without drive", nodrv_err, 0);
    chk(rel_err == 0, "R7", "drive before bus release", rel_err, 0);
    chk(ovl_err == 0, "R4", "write with output enabled", ovl_err, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule